// File: doc/BRIEF.md
# Crank-Angle Synchronous Pressure Capture

This block turns a free-running stream of pressure samples into exactly one sample per crank-angle step of an engine cycle. It tracks the crank position from the incremental A phase and the once-per-revolution Z phase of a shaft encoder. One engine cycle covers two crankshaft revolutions, and the tracked index runs from 0 to `CYCLE_POS-1`. The block keeps the most recent sample from an ADC-style input. Each time the angle index moves, it offers one packed 32-bit word to an external FIFO write port.

A host sets a cycle count and pulses a request. The block then waits for the angle index to next arrive at 0 and emits that many complete cycles of words. After that it returns to idle by itself. The write port never waits on the FIFO. When the FIFO reports full, the word is lost and a sticky flag records the loss. Every word carries its own angle, so the host can place any word in the cycle without counting.

Top module: `crank_capture`

## Requirements
- R1: Each rising edge of the A input moves the angle index up by one. From `CYCLE_POS-1` the index wraps to 0.
- R2: Rising edges of Z alternate between starting a first and a second revolution. Only the Z edge that starts a first revolution forces the index to 0. The first Z edge after reset counts as starting a first revolution. At the other Z edge the index does not change.
- R3: A word is offered only for a clock on which the angle index differs from its value on the previous clock, so there is one word per angle step. Word layout: the angle index is in bits starting at bit 16, the sample is in bits [15:0], and all other bits are 0.
- R4: The sample field holds the latest value presented with `sample_valid_i` high before the angle step.
- R5: After a request is accepted, nothing is written until the index next changes to 0. The first word of a capture has angle 0.
- R6: A capture of N cycles emits exactly N×`CYCLE_POS` words, with angles ascending from 0 to `CYCLE_POS-1` in each cycle. `busy_o` is high from the clock after the request until the clock on which the last word appears. After that the block is idle.
- R7: A request while `busy_o` is high has no effect. A request with a cycle count of 0 is ignored.
- R8: While `fifo_full_i` is high, a due word is dropped instead of written, and the capture keeps counting. `overflow_o` sets on any drop, stays set, and clears only when a request is accepted.
- R9: After reset, `busy_o`, `overflow_o` and `fifo_wr_en_o` are low.
- R10: While idle, angle steps produce no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a_i | input | 1 | Encoder incremental phase, one rising edge per angle step |
| enc_z_i | input | 1 | Encoder once-per-revolution index phase |
| sample_valid_i | input | 1 | Qualifies a new pressure sample |
| sample_i | input | SAMPLE_W | Pressure sample value |
| start_i | input | 1 | Capture request pulse |
| n_cycles_i | input | CYC_W | Number of engine cycles to capture |
| fifo_full_i | input | 1 | External FIFO cannot take a word this clock |
| fifo_wr_en_o | output | 1 | Write strobe for the external FIFO |
| fifo_wr_data_o | output | WORD_W | Packed angle and sample word |
| busy_o | output | 1 | A capture is armed or running |
| overflow_o | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The bench builds the block with `CYCLE_POS` = 12 and a 4-bit cycle count. At that size a full engine cycle is only six encoder pulses per revolution, so every angle position, both wraps (through A and through the first-revolution Z) and both arming paths can each be covered in a few hundred clocks. Cycle counts 1 to 3 are swept, and every emitted word is compared to a bench model of the encoder and sample history. Requests while busy, zero-count requests and a capture that runs entirely against a full FIFO are also covered.

// File: rtl/crank_cap_pkg.sv
package crank_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/crank_angle_tracker.sv
module crank_angle_tracker #(
    parameter  int CYCLE_POS = 720,
    localparam int AW        = $clog2(CYCLE_POS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_a_i,
    input  logic          enc_z_i,
    output logic [AW-1:0] angle_o
);
    localparam logic [AW-1:0] LAST = AW'(CYCLE_POS - 1);

    typedef struct packed {
        logic          a_prev;
        logic          z_prev;
        logic          second_rev;
        logic [AW-1:0] angle;
    } trk_t;

    trk_t trk_d, trk_q;
    logic a_rise, z_rise;

    always_comb begin
        trk_d        = trk_q;
        trk_d.a_prev = enc_a_i;
        trk_d.z_prev = enc_z_i;
        a_rise       = enc_a_i & ~trk_q.a_prev;
        z_rise       = enc_z_i & ~trk_q.z_prev;
        if (z_rise) begin
            trk_d.second_rev = ~trk_q.second_rev;
        end
        if (z_rise && trk_q.second_rev) begin
            // Z edge that opens the first revolution re-anchors the index
            trk_d.angle = '0;
        end else if (a_rise) begin
            trk_d.angle = (trk_q.angle == LAST) ? '0 : trk_q.angle + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q            <= '0;
            trk_q.second_rev <= 1'b1;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign angle_o = trk_q.angle;
endmodule

// File: rtl/sample_holder.sv
module sample_holder #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [SAMPLE_W-1:0] data_i,
    output logic [SAMPLE_W-1:0] held_o
);
    logic [SAMPLE_W-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (valid_i) held_d = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held_o = held_q;
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
    import crank_cap_pkg::*;
#(
    parameter  int CYCLE_POS = 720,
    parameter  int SAMPLE_W  = 16,
    parameter  int WORD_W    = 32,
    parameter  int ANGLE_LSB = 16,
    parameter  int CYC_W     = 8,
    localparam int AW        = $clog2(CYCLE_POS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       angle_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                start_i,
    input  logic [CYC_W-1:0]    n_cycles_i,
    input  logic                fifo_full_i,
    output logic                wr_en_o,
    output logic [WORD_W-1:0]   wr_data_o,
    output logic                busy_o,
    output logic                overflow_o
);
    localparam logic [AW-1:0] LAST = AW'(CYCLE_POS - 1);

    typedef struct packed {
        cap_state_e         state;
        logic [AW-1:0]      angle_prev;
        logic [CYC_W-1:0]   cyc_left;
        logic               wr_en;
        logic [WORD_W-1:0]  wr_data;
        logic               ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic changed, emit;
    logic [WORD_W-1:0] word;

    always_comb begin
        word = '0;
        word[SAMPLE_W-1:0]     = sample_i;
        word[ANGLE_LSB +: AW]  = angle_i;
    end

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.angle_prev = angle_i;
        ctl_d.wr_en      = 1'b0;
        changed          = (angle_i != ctl_q.angle_prev);
        emit             = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i && (n_cycles_i != '0)) begin
                    ctl_d.state    = ST_ARM;
                    ctl_d.cyc_left = n_cycles_i;
                    ctl_d.ovf      = 1'b0;
                end
            end
            ST_ARM: begin
                if (changed && (angle_i == '0)) begin
                    emit        = 1'b1;
                    ctl_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (changed) begin
                    emit = 1'b1;
                    if (angle_i == LAST) begin
                        if (ctl_q.cyc_left == CYC_W'(1)) ctl_d.state = ST_IDLE;
                        ctl_d.cyc_left = ctl_q.cyc_left - CYC_W'(1);
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (emit) begin
            if (fifo_full_i) begin
                ctl_d.ovf = 1'b1;
            end else begin
                ctl_d.wr_en   = 1'b1;
                ctl_d.wr_data = word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wr_en_o    = ctl_q.wr_en;
    assign wr_data_o  = ctl_q.wr_data;
    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign overflow_o = ctl_q.ovf;
endmodule

// File: rtl/crank_capture.sv
module crank_capture #(
    parameter  int CYCLE_POS = 720,
    parameter  int SAMPLE_W  = 16,
    parameter  int WORD_W    = 32,
    parameter  int ANGLE_LSB = 16,
    parameter  int CYC_W     = 8,
    localparam int AW        = $clog2(CYCLE_POS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enc_a_i,
    input  logic                enc_z_i,
    input  logic                sample_valid_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                start_i,
    input  logic [CYC_W-1:0]    n_cycles_i,
    input  logic                fifo_full_i,
    output logic                fifo_wr_en_o,
    output logic [WORD_W-1:0]   fifo_wr_data_o,
    output logic                busy_o,
    output logic                overflow_o
);
    logic [AW-1:0]       angle;
    logic [SAMPLE_W-1:0] held;

    crank_angle_tracker #(.CYCLE_POS(CYCLE_POS)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .enc_a_i (enc_a_i),
        .enc_z_i (enc_z_i),
        .angle_o (angle)
    );

    sample_holder #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (sample_valid_i),
        .data_i  (sample_i),
        .held_o  (held)
    );

    capture_ctrl #(
        .CYCLE_POS (CYCLE_POS),
        .SAMPLE_W  (SAMPLE_W),
        .WORD_W    (WORD_W),
        .ANGLE_LSB (ANGLE_LSB),
        .CYC_W     (CYC_W)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .angle_i     (angle),
        .sample_i    (held),
        .start_i     (start_i),
        .n_cycles_i  (n_cycles_i),
        .fifo_full_i (fifo_full_i),
        .wr_en_o     (fifo_wr_en_o),
        .wr_data_o   (fifo_wr_data_o),
        .busy_o      (busy_o),
        .overflow_o  (overflow_o)
    );
endmodule

// File: rtl/crank_capture_chk.sv
module crank_capture_chk #(
    parameter  int CYCLE_POS = 720,
    parameter  int WORD_W    = 32,
    parameter  int ANGLE_LSB = 16,
    parameter  int CYC_W     = 8,
    localparam int AW        = $clog2(CYCLE_POS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CYC_W-1:0]  n_cycles_i,
    input logic              fifo_full_i,
    input logic              fifo_wr_en_o,
    input logic [WORD_W-1:0] fifo_wr_data_o,
    input logic              busy_o,
    input logic              overflow_o
);
    logic accept;
    assign accept = start_i && !busy_o && (n_cycles_i != '0);

    // R3: angle field in range and bits above it clear
    p_word_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en_o |-> ((32'(fifo_wr_data_o[ANGLE_LSB +: AW]) < CYCLE_POS)
                          && ((fifo_wr_data_o >> (ANGLE_LSB + AW)) == '0)));

    // R10: idle on two consecutive clocks means no write
    p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> !fifo_wr_en_o);

    // R8: a full FIFO on the deciding clock suppresses the write
    p_full_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en_o |-> !$past(fifo_full_i));

    // R8: overflow holds until a request
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overflow_o) && !$past(start_i)) |-> overflow_o);

    // R8: accepted request clears overflow
    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !overflow_o);

    // R6: accepted request raises busy
    p_busy_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    // R7: zero-count request while idle keeps the block idle
    p_zero_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (n_cycles_i == '0)) |=> !busy_o);
endmodule

bind crank_capture crank_capture_chk #(
    .CYCLE_POS (CYCLE_POS),
    .WORD_W    (WORD_W),
    .ANGLE_LSB (ANGLE_LSB),
    .CYC_W     (CYC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .n_cycles_i     (n_cycles_i),
    .fifo_full_i    (fifo_full_i),
    .fifo_wr_en_o   (fifo_wr_en_o),
    .fifo_wr_data_o (fifo_wr_data_o),
    .busy_o         (busy_o),
    .overflow_o     (overflow_o)
);

// File: tb/crank_capture_tb.sv
`timescale 1ns/1ps
module crank_capture_tb;
    localparam int CP = 12;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a_i = 1'b0, enc_z_i = 1'b0;
    logic        sample_valid_i = 1'b0;
    logic [15:0] sample_i = '0;
    logic        start_i = 1'b0;
    logic [CW-1:0] n_cycles_i = '0;
    logic        fifo_full_i = 1'b0;
    logic        fifo_wr_en_o;
    logic [31:0] fifo_wr_data_o;
    logic        busy_o, overflow_o;

    always #2.5 clk = ~clk;

    crank_capture #(.CYCLE_POS(CP), .CYC_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a_i(enc_a_i), .enc_z_i(enc_z_i),
        .sample_valid_i(sample_valid_i), .sample_i(sample_i),
        .start_i(start_i), .n_cycles_i(n_cycles_i), .fifo_full_i(fifo_full_i),
        .fifo_wr_en_o(fifo_wr_en_o), .fifo_wr_data_o(fifo_wr_data_o),
        .busy_o(busy_o), .overflow_o(overflow_o)
    );

    int checks = 0, errors = 0;
    logic [31:0] cap_w [0:1023];
    int cap_n = 0;
    int step_ang [0:2047];
    int step_smp [0:2047];
    int n_steps = 0;
    int m_ang = 0;
    bit m_second = 1'b1;
    int m_smp = 0;
    int s_ctr = 0;

    always @(negedge clk) begin
        if (rst_n && fifo_wr_en_o && cap_n < 1024) begin
            cap_w[cap_n] = fifo_wr_data_o;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic move_to(input int nw);
        if (nw != m_ang && n_steps < 2048) begin
            step_ang[n_steps] = nw;
            step_smp[n_steps] = m_smp;
            n_steps++;
        end
        m_ang = nw;
    endtask

    task automatic a_pulse();
        s_ctr++;
        sample_i = 16'(s_ctr * 7 + 3);
        m_smp = s_ctr * 7 + 3;
        sample_valid_i = 1'b1;
        @(negedge clk);
        sample_valid_i = 1'b0;
        enc_a_i = 1'b1;
        repeat (2) @(negedge clk);
        enc_a_i = 1'b0;
        repeat (2) @(negedge clk);
        move_to((m_ang == CP - 1) ? 0 : m_ang + 1);
    endtask

    task automatic z_pulse();
        enc_z_i = 1'b1;
        repeat (2) @(negedge clk);
        enc_z_i = 1'b0;
        repeat (2) @(negedge clk);
        if (m_second) begin
            m_second = 1'b0;
            move_to(0);
        end else begin
            m_second = 1'b1;
        end
    endtask

    task automatic rev();
        z_pulse();
        repeat (CP / 2) a_pulse();
    endtask

    task automatic request(input int n);
        start_i = 1'b1;
        n_cycles_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic spin_until_idle();
        for (int g = 0; g < 40 && busy_o; g++) rev();
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(input int n, input int sstep, input int base);
        int f = -1;
        for (int i = sstep; i < n_steps; i++) begin
            if (step_ang[i] == 0) begin f = i; break; end
        end
        chk(cap_n - base == n * CP, "R6 word count", cap_n - base, n * CP);
        chk(busy_o == 1'b0, "R6 idle after capture", int'(busy_o), 0);
        if (cap_n > base)
            chk(cap_w[base][25:16] == 10'd0, "R5 first angle", int'(cap_w[base][25:16]), 0);
        for (int i = 0; i < n * CP && i < cap_n - base && f >= 0; i++) begin
            logic [31:0] e;
            e = (32'(step_ang[f + i]) << 16) | 32'(step_smp[f + i] & 16'hFFFF);
            chk(cap_w[base + i] == e, "R3/R4/R1/R2 word", int'(cap_w[base + i]), int'(e));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int sstep, base;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(busy_o == 1'b0, "R9 busy", int'(busy_o), 0);
        chk(overflow_o == 1'b0, "R9 overflow", int'(overflow_o), 0);
        chk(fifo_wr_en_o == 1'b0, "R9 wr_en", int'(fifo_wr_en_o), 0);

        // R10: idle spinning writes nothing
        rev(); rev();
        chk(cap_n == 0, "R10 idle writes", cap_n, 0);

        // R5/R2: start away from zero, Z re-anchor provides the first 0
        repeat (3) a_pulse();
        sstep = n_steps; base = cap_n;
        request(1);
        chk(busy_o == 1'b1, "R6 busy after request", int'(busy_o), 1);
        spin_until_idle();
        verify(1, sstep, base);

        // R1/R6: sweep cycle counts, arming through the A wrap
        for (int n = 1; n <= 3; n++) begin
            sstep = n_steps; base = cap_n;
            request(n);
            spin_until_idle();
            verify(n, sstep, base);
        end

        // R7: zero count ignored
        request(0);
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 zero count", int'(busy_o), 0);

        // R7: request while busy ignored
        sstep = n_steps; base = cap_n;
        request(1);
        rev();
        request(3);
        spin_until_idle();
        verify(1, sstep, base);

        // R8: full FIFO drops everything, no stall, overflow sticky
        fifo_full_i = 1'b1;
        base = cap_n;
        request(1);
        spin_until_idle();
        chk(cap_n - base == 0, "R8 dropped words", cap_n - base, 0);
        chk(busy_o == 1'b0, "R8 no stall", int'(busy_o), 0);
        chk(overflow_o == 1'b1, "R8 overflow set", int'(overflow_o), 1);
        fifo_full_i = 1'b0;
        rev();
        chk(overflow_o == 1'b1, "R8 overflow sticky", int'(overflow_o), 1);
        sstep = n_steps; base = cap_n;
        request(1);
        chk(overflow_o == 1'b0, "R8 overflow cleared", int'(overflow_o), 0);
        spin_until_idle();
        verify(1, sstep, base);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule